// File: doc/BRIEF.md
# PCM Time Slot Gating Unit

This unit produces the receive-enable and transmit-enable windows that gate a serial HDLC channel on a time-division PCM highway. A bit counter restarts at every rising edge of the frame sync input. Each direction has its own slot number and bit shift, so the two windows are placed independently. Each window opens a programmed number of bit clocks after the sync edge and stays open for a programmed width of 1 to 256 bits. An external serializer and deserializer use the two enables to decide which bit periods belong to the channel.

The slot configuration byte of each direction holds the 6-bit slot number in bits 7..2, and bits 1..0 are reserved. The window start is 8 × slot number + shift. The two windows share one width field, which holds the width minus one. The enables are retimed to the falling edge of the bit clock, so the downstream shift registers, which sample on the rising edge, always see a settled gate.

Each direction runs one window state machine with four states. `W_IDLE` is entered at reset and held until the first sync edge. `W_WAIT` counts toward the start position. `W_OPEN` marks the bits inside the window. `W_DONE` means the window is spent for this frame. The transitions are as follows:
- sync edge from any state: to `W_OPEN` when the start is 0, otherwise to `W_WAIT`.
- `W_WAIT` to `W_OPEN` when the bit position equals the start.
- `W_OPEN` to `W_DONE` when the remaining-bit count is zero.
- `W_OPEN` stays in `W_OPEN` and decrements the remaining-bit count otherwise.
- `W_IDLE` and `W_DONE` hold until the next sync edge.

Top module: `pcm_slot_gate`

## Requirements
- R1: While `rst_n` is low, and after reset until the first rising frame sync edge, both `rx_en` and `tx_en` are 0. Reset clears the enables asynchronously.
- R2: A frame starts only at a rising clock edge where `fsync` is 1 and was 0 at the previous rising clock edge. That clock edge is bit index 0. Holding `fsync` high for several bits does not restart the count.
- R3: The window of a direction starts at bit index 8 × TSN + shift. TSN is bits 7..2 of that direction's slot configuration byte, and the shift is its 3-bit shift input.
- R4: A window covers exactly `width_m1` + 1 consecutive bit indices, from 1 to 256.
- R5: The receive and transmit windows use their own slot and shift values and are placed independently of each other.
- R6: A rising frame sync edge that arrives while a window is still open ends that window. The new frame's window is then scheduled from bit index 0 again.
- R7: An enable changes only on a falling clock edge. Bit index e is inside the window when the enable is 1 between the falling edge after rising edge e and the next rising edge.
- R8: Bits 1..0 of the slot configuration bytes have no effect on the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; state advances on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame synchronization, sampled on the rising edge |
| rx_slot_cfg | input | 8 | Receive slot number in bits 7..2; bits 1..0 reserved |
| rx_shift | input | 3 | Receive bit shift, 0 to 7 |
| tx_slot_cfg | input | 8 | Transmit slot number in bits 7..2; bits 1..0 reserved |
| tx_shift | input | 3 | Transmit bit shift, 0 to 7 |
| width_m1 | input | 8 | Window width minus one, shared by both directions |
| rx_en | output | 1 | Receive enable, updated on the falling edge |
| tx_en | output | 1 | Transmit enable, updated on the falling edge |

## Verification
The assertions assume that the slot, shift and width inputs are stable from one frame sync edge to the next. They also assume that `fsync` meets the rising-edge sampling setup. The bench writes new configuration only after the last bit of a frame and before the sync edge of the next one. It moves `fsync` and samples the enables at a quarter period before each rising edge, so no input changes near an active edge. The stimulus includes frames that are cut short by a new sync edge, windows that reach past the frame end, and a sync pulse held high for several bits.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    // Per-direction window progress within one frame.
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,   // no sync seen since reset
        W_WAIT = 2'd1,   // counting toward the window start
        W_OPEN = 2'd2,   // current bit is inside the window
        W_DONE = 2'd3    // window spent for this frame
    } win_state_e;

    localparam int unsigned NUM_DIR = 2;   // receive, transmit
    localparam int unsigned DIR_RX  = 0;
    localparam int unsigned DIR_TX  = 1;

endpackage

// File: rtl/tsg_bit_counter.sv
module tsg_bit_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             sync_pulse,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic fsync_q;

    // Rising-edge detection against the level seen at the previous edge.
    always_comb begin
        sync_pulse = fsync & ~fsync_q;
        if (sync_pulse) begin
            pos = '0;
        end else if (cnt_q == CNT_MAX) begin
            pos = cnt_q;
        end else begin
            pos = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            fsync_q <= fsync;
            cnt_q   <= pos;
        end
    end

    // R2: between sync edges the position advances by exactly one bit
    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2: a sync edge always lands the counter on bit index 0
    a_r2_sync_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> (cnt_q == '0));

endmodule

// File: rtl/tsg_window_fsm.sv
module tsg_window_fsm
    import tsg_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] start,
    input  logic [WID_W-1:0] width_m1,
    output logic             en
);

    win_state_e       state_q, state_d;
    logic [WID_W-1:0] rem_q, rem_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        if (sync_pulse) begin
            if (start == '0) begin
                state_d = W_OPEN;
                rem_d   = width_m1;
            end else begin
                state_d = W_WAIT;
            end
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    state_d = W_IDLE;
                end
                W_WAIT: begin
                    if (pos == start) begin
                        state_d = W_OPEN;
                        rem_d   = width_m1;
                    end
                end
                W_OPEN: begin
                    if (rem_q == '0) begin
                        state_d = W_DONE;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
                W_DONE: begin
                    state_d = W_DONE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Output register on the opposite edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else begin
            en <= (state_q == W_OPEN);
        end
    end

    // R1: no enable before the first frame sync
    a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_IDLE) |-> !en);

    // R3: a window only opens on its programmed start position
    a_r3_opens_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == W_OPEN) |-> (cnt_q == start));

    // R4: the last window bit is followed by a closed window unless a new frame begins
    a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_OPEN && rem_q == '0 && !sync_pulse) |=> (state_q == W_DONE));

    // R6: a sync edge restarts the schedule from any state
    a_r6_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> (state_q == W_WAIT || state_q == W_OPEN));

    // R7: by each rising edge the enable already reflects the state set at the previous one
    a_r7_en_settled: assert property (@(posedge clk) disable iff (!rst_n)
        en == (state_q == W_OPEN));

endmodule

// File: rtl/pcm_slot_gate.sv
module pcm_slot_gate
    import tsg_pkg::*;
#(
    parameter int unsigned TSN_W   = 6,
    parameter int unsigned SHIFT_W = 3,
    parameter int unsigned WID_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic [TSN_W+1:0]     rx_slot_cfg,
    input  logic [SHIFT_W-1:0]   rx_shift,
    input  logic [TSN_W+1:0]     tx_slot_cfg,
    input  logic [SHIFT_W-1:0]   tx_shift,
    input  logic [WID_W-1:0]     width_m1,
    output logic                 rx_en,
    output logic                 tx_en
);

    localparam int unsigned CFG_W   = TSN_W + 2;
    localparam int unsigned START_W = TSN_W + SHIFT_W;
    localparam int unsigned CNT_W   = START_W + 1;

    logic               sync_pulse;
    logic [CNT_W-1:0]   pos;
    logic [CNT_W-1:0]   cnt_q;

    logic [CFG_W-1:0]   cfg_arr   [NUM_DIR];
    logic [SHIFT_W-1:0] shift_arr [NUM_DIR];
    logic [NUM_DIR-1:0] en_vec;

    // Reserved configuration bits are read nowhere else.
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{rx_slot_cfg[1:0], tx_slot_cfg[1:0]};

    assign cfg_arr[DIR_RX]   = rx_slot_cfg;
    assign cfg_arr[DIR_TX]   = tx_slot_cfg;
    assign shift_arr[DIR_RX] = rx_shift;
    assign shift_arr[DIR_TX] = tx_shift;
    assign rx_en = en_vec[DIR_RX];
    assign tx_en = en_vec[DIR_TX];

    tsg_bit_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .sync_pulse (sync_pulse),
        .pos        (pos),
        .cnt_q      (cnt_q)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic [CNT_W-1:0] start;

        // slot number * 8 + shift is a plain concatenation
        assign start = CNT_W'({cfg_arr[d][CFG_W-1:2], shift_arr[d]});

        tsg_window_fsm #(
            .CNT_W (CNT_W),
            .WID_W (WID_W)
        ) i_window (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_pulse (sync_pulse),
            .pos        (pos),
            .cnt_q      (cnt_q),
            .start      (start),
            .width_m1   (width_m1),
            .en         (en_vec[d])
        );
    end

    // R5: each window honours its own start even when the other is elsewhere
    a_r5_rx_tx_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (g_dir[0].start != g_dir[1].start && sync_pulse && width_m1 == '0)
        |=> !(g_dir[0].i_window.state_q == W_OPEN && g_dir[1].i_window.state_q == W_OPEN));

endmodule

// File: tb/test_pcm_slot_gate.sv
module test_pcm_slot_gate;

    typedef struct packed {
        logic [7:0]  rxc;
        logic [2:0]  rxs;
        logic [7:0]  txc;
        logic [2:0]  txs;
        logic [7:0]  wm1;
        logic [10:0] flen;
        logic [3:0]  hi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h08, 3'd3, 8'h00, 3'd5, 8'd7,   11'd64,  4'd1},
        '{8'h07, 3'd0, 8'h12, 3'd7, 8'd0,   11'd60,  4'd3},
        '{8'h00, 3'd0, 8'h05, 3'd1, 8'd255, 11'd300, 4'd1},
        '{8'h1C, 3'd0, 8'hFC, 3'd7, 8'd31,  11'd70,  4'd2},
        '{8'h04, 3'd0, 8'h01, 3'd2, 8'd3,   11'd20,  4'd1},
        '{8'h0C, 3'd2, 8'hFF, 3'd7, 8'd15,  11'd520, 4'd1}
    };
    string tags [NV] = '{"R3 R5", "R2 R4 R8", "R3 R4", "R6 R4", "R6 R8", "R3 R5"};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fsync;
    logic [7:0] rx_slot_cfg, tx_slot_cfg, width_m1;
    logic [2:0] rx_shift, tx_shift;
    logic       rx_en, tx_en;

    int n_vec = 0;
    int n_bad = 0;
    bit prev_rx = 1'b0;
    bit prev_tx = 1'b0;

    always #10 clk = ~clk;

    pcm_slot_gate i_pcm_slot_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .rx_slot_cfg (rx_slot_cfg),
        .rx_shift    (rx_shift),
        .tx_slot_cfg (tx_slot_cfg),
        .tx_shift    (tx_shift),
        .width_m1    (width_m1),
        .rx_en       (rx_en),
        .tx_en       (tx_en)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit in_win(input logic [7:0] cfg, input logic [2:0] sh,
                                  input logic [7:0] wm1, input int e);
        int st;
        st = int'(cfg[7:2]) * 8 + int'(sh);
        return (e >= st) && (e < st + int'(wm1) + 1);
    endfunction

    // Called a quarter period before a rising edge; ends at the same phase.
    task automatic run_frame(input vec_t v, input string tag);
        rx_slot_cfg = v.rxc;
        rx_shift    = v.rxs;
        tx_slot_cfg = v.txc;
        tx_shift    = v.txs;
        width_m1    = v.wm1;
        for (int e = 0; e < int'(v.flen); e++) begin
            bit erx;
            bit etx;
            fsync = (e < int'(v.hi));
            erx = in_win(v.rxc, v.rxs, v.wm1, e);
            etx = in_win(v.txc, v.txs, v.wm1, e);
            @(posedge clk);
            #5;
            chk({tag, " R7"}, "rx_en held past rising edge", rx_en, prev_rx);
            chk({tag, " R7"}, "tx_en held past rising edge", tx_en, prev_tx);
            #10;
            chk(tag, "rx_en window", rx_en, erx);
            chk(tag, "tx_en window", tx_en, etx);
            prev_rx = erx;
            prev_tx = etx;
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        rst_n       = 1'b0;
        fsync       = 1'b0;
        rx_slot_cfg = 8'h00;
        rx_shift    = 3'd0;
        tx_slot_cfg = 8'h00;
        tx_shift    = 3'd0;
        width_m1    = 8'd3;

        // R1: enables low in reset
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "rx_en in reset", rx_en, 1'b0);
        chk("R1", "tx_en in reset", tx_en, 1'b0);
        @(posedge clk);
        #15;
        rst_n = 1'b1;

        // R1: start 0 configured, but no sync yet
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            #15;
            chk("R1", "rx_en before first sync", rx_en, 1'b0);
            chk("R1", "tx_en before first sync", tx_en, 1'b0);
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i], tags[i]);
        end

        // R1: reset in the middle of an open window
        run_frame('{8'h00, 3'd0, 8'h00, 3'd1, 8'd255, 11'd10, 4'd1}, "R3 R4");
        rst_n = 1'b0;
        #2;
        chk("R1", "rx_en cleared by reset", rx_en, 1'b0);
        chk("R1", "tx_en cleared by reset", tx_en, 1'b0);
        @(posedge clk);
        #15;
        rst_n   = 1'b1;
        prev_rx = 1'b0;
        prev_tx = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #15;
            chk("R1", "rx_en after reset, no sync", rx_en, 1'b0);
            chk("R1", "tx_en after reset, no sync", tx_en, 1'b0);
        end

        // Recovery after reset
        run_frame('{8'h04, 3'd1, 8'h09, 3'd4, 8'd5, 11'd40, 4'd1}, "R1 R3 R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule